// File: doc/BRIEF.md
# Speculative Cache Line Tracker

This block holds the per-line state that a data cache needs when its core runs under redundant execution and its results have not yet been checked against a second copy. Every line has three bits: valid, dirty and speculative. A write hit marks its line speculative. A speculative line is locked. It cannot leave the cache until a comparison of execution fingerprints has confirmed the results that produced it.

The cache controller offers evictions by line index. A line that is not speculative is released in the same cycle, and a writeback strobe is raised only if the line holds dirty data. A speculative victim instead raises a compare request, and the block goes busy. The eviction stalls while the block is busy and the requester holds its request. A verification result then acts on every line in a single cycle. A match unlocks all speculative lines and keeps their data. A mismatch invalidates exactly the speculative lines, so their data is dropped and never reaches memory. After the result, the held eviction completes with or without a writeback, depending on the outcome.

Tag lookup, data storage and fingerprint generation stay outside the block.

Top module: `spec_line_tracker`

## Requirements
- R1: A write hit (`wr_valid`=1) sets the valid, dirty and speculative bits of line `wr_idx` at the next clock edge.
- R2: `evict_wb` is never 1 for a line whose speculative bit is set.
- R3: An eviction request for a speculative line, while the block is not busy and `chk_valid`=0, raises `cmp_req` for that one cycle without `evict_ack`, and `busy` is 1 from the next cycle.
- R4: `busy` stays 1 until a cycle with `chk_valid`=1 and is 0 in the cycle after it. While `busy`=1, `cmp_req` and `evict_ack` stay 0, and a held request shows `evict_stall`=1 (`evict_stall` = `evict_req` and not `evict_ack`).
- R5: A result with `chk_valid`=1 and `chk_match`=1 clears every speculative bit in one cycle and leaves valid and dirty unchanged. A held eviction of such a line then completes with `evict_wb`=1.
- R6: A result with `chk_valid`=1 and `chk_match`=0 invalidates every line that is speculative, in one cycle, and leaves other lines unchanged. A held eviction of such a line then completes with `evict_wb`=0.
- R7: When `busy`=0, an eviction request for a non-speculative line is acknowledged in the same cycle with no compare. `evict_wb` is 1 exactly when the line is valid and dirty.
- R8: A line that has been acknowledged for eviction is invalid from the next cycle, unless it is written in that same cycle.
- R9: When a write and a verification result fall in the same cycle, the result is applied first. The written line ends up valid, dirty and speculative.
- R10: `spec_any` is 1 exactly when at least one line is speculative.
- R11: After reset every line is invalid and clean, no line is speculative, and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write hit strobe |
| wr_idx | input | IDX_W | Line written |
| evict_req | input | 1 | Eviction request, held while stalled |
| evict_idx | input | IDX_W | Victim line, held while stalled |
| evict_ack | output | 1 | Eviction accepted this cycle |
| evict_wb | output | 1 | Accepted victim must be written back |
| evict_stall | output | 1 | Request present but not accepted |
| cmp_req | output | 1 | Fingerprint compare requested |
| chk_valid | input | 1 | Verification result strobe |
| chk_match | input | 1 | Result: 1 match, 0 mismatch |
| busy | output | 1 | Eviction-triggered compare pending |
| spec_any | output | 1 | Some line is speculative |

## Verification
The checker assumes that a stalled requester keeps `evict_req` high and `evict_idx` unchanged until the request is acknowledged. It also assumes that `chk_valid` is a one-cycle strobe, which may arrive unsolicited as well as in answer to `cmp_req`. The invalidation property for an acknowledged line excludes a write in the same cycle, because the write re-validates the line. The random stimulus re-drives the previous request whenever the sampled stall flag is high. It sends results as sparse single-cycle pulses and aims writes at any line, including the current victim.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic spec;
  } line_st_t;

  typedef enum logic [1:0] {
    FLASH_NONE  = 2'd0,
    FLASH_CLEAR = 2'd1,
    FLASH_KILL  = 2'd2
  } flash_op_t;

endpackage

// File: rtl/spec_line_cell.sv
module spec_line_cell
  import spec_trk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  logic      ev_clr,
  input  flash_op_t flash,
  output line_st_t  st
);

  line_st_t st_nxt;
  logic     st_en;

  // order: eviction release, then flash result, then write
  always_comb begin
    st_nxt = st;
    if (ev_clr) st_nxt = '0;
    case (flash)
      FLASH_CLEAR: if (st_nxt.spec) st_nxt.spec = 1'b0;
      FLASH_KILL:  if (st_nxt.spec) st_nxt = '0;
      default: ;
    endcase
    if (wr_hit) st_nxt = '{valid: 1'b1, dirty: 1'b1, spec: 1'b1};
  end

  assign st_en = wr_hit | ev_clr | (flash != FLASH_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= '0;
    else if (st_en) st <= st_nxt;
  end

endmodule

// File: rtl/spec_line_array.sv
module spec_line_array
  import spec_trk_pkg::*;
#(
  parameter int NLINES = 64,
  parameter int IDX_W  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              ev_ack,
  input  logic [IDX_W-1:0]  ev_idx,
  input  flash_op_t         flash,
  output logic [NLINES-1:0] valid_vec,
  output logic [NLINES-1:0] dirty_vec,
  output logic [NLINES-1:0] spec_vec
);

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
    line_st_t st;
    logic     hit;
    logic     clr;

    assign hit = wr_valid && (wr_idx == IDX_W'(gi));
    assign clr = ev_ack && (ev_idx == IDX_W'(gi));

    spec_line_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hit),
      .ev_clr (clr),
      .flash  (flash),
      .st     (st)
    );

    assign valid_vec[gi] = st.valid;
    assign dirty_vec[gi] = st.dirty;
    assign spec_vec[gi]  = st.spec;
  end

endmodule

// File: rtl/spec_evict_ctrl.sv
module spec_evict_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evict_req,
  input  logic sel_valid,
  input  logic sel_dirty,
  input  logic sel_spec,
  input  logic chk_valid,
  output logic evict_ack,
  output logic evict_wb,
  output logic evict_stall,
  output logic cmp_req,
  output logic busy
);

  logic busy_nxt;
  logic busy_en;

  assign evict_ack   = evict_req && !busy && !sel_spec;
  assign evict_wb    = evict_ack && sel_valid && sel_dirty;
  assign evict_stall = evict_req && !evict_ack;
  assign cmp_req     = evict_req && !busy && sel_spec && !chk_valid;

  always_comb begin
    busy_nxt = busy;
    if (chk_valid)    busy_nxt = 1'b0;
    else if (cmp_req) busy_nxt = 1'b1;
  end

  assign busy_en = chk_valid | cmp_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy <= 1'b0;
    else if (busy_en) busy <= busy_nxt;
  end

endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
  import spec_trk_pkg::*;
#(
  parameter int NLINES = 64,
  parameter int IDX_W  = $clog2(NLINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             evict_req,
  input  logic [IDX_W-1:0] evict_idx,
  output logic             evict_ack,
  output logic             evict_wb,
  output logic             evict_stall,
  output logic             cmp_req,
  input  logic             chk_valid,
  input  logic             chk_match,
  output logic             busy,
  output logic             spec_any
);

  logic [NLINES-1:0] valid_vec;
  logic [NLINES-1:0] dirty_vec;
  logic [NLINES-1:0] spec_vec;
  flash_op_t         flash;

  always_comb begin
    flash = FLASH_NONE;
    if (chk_valid) flash = chk_match ? FLASH_CLEAR : FLASH_KILL;
  end

  spec_line_array #(.NLINES(NLINES), .IDX_W(IDX_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .ev_ack    (evict_ack),
    .ev_idx    (evict_idx),
    .flash     (flash),
    .valid_vec (valid_vec),
    .dirty_vec (dirty_vec),
    .spec_vec  (spec_vec)
  );

  spec_evict_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evict_req   (evict_req),
    .sel_valid   (valid_vec[evict_idx]),
    .sel_dirty   (dirty_vec[evict_idx]),
    .sel_spec    (spec_vec[evict_idx]),
    .chk_valid   (chk_valid),
    .evict_ack   (evict_ack),
    .evict_wb    (evict_wb),
    .evict_stall (evict_stall),
    .cmp_req     (cmp_req),
    .busy        (busy)
  );

  assign spec_any = |spec_vec;

endmodule

// File: rtl/spec_line_tracker_chk.sv
module spec_line_tracker_chk #(
  parameter int NLINES = 64,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [IDX_W-1:0]  evict_idx,
  input logic              evict_req,
  input logic              evict_ack,
  input logic              evict_wb,
  input logic              cmp_req,
  input logic              chk_valid,
  input logic              chk_match,
  input logic              busy,
  input logic              spec_any,
  input logic [NLINES-1:0] valid_vec,
  input logic [NLINES-1:0] spec_vec
);

  a_r2_no_spec_wb: assert property (@(posedge clk) disable iff (!rst_n)
    evict_wb |-> !spec_vec[evict_idx]);

  a_r3_cmp_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |=> busy);

  a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !chk_valid) |=> busy);

  a_r4_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> !busy);

  a_r4_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cmp_req && !evict_ack));

  a_r5_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_match && !wr_valid) |=> !spec_any);

  a_r6_mismatch_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_match && !wr_valid) |=> ((valid_vec & $past(spec_vec)) == '0));

  a_r7_nonspec_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_req && !busy && !spec_vec[evict_idx]) |-> evict_ack);

  a_r8_ack_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_ack && !wr_valid) |=> !valid_vec[$past(evict_idx)]);

endmodule

bind spec_line_tracker spec_line_tracker_chk #(.NLINES(NLINES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .evict_idx (evict_idx),
  .evict_req (evict_req),
  .evict_ack (evict_ack),
  .evict_wb  (evict_wb),
  .cmp_req   (cmp_req),
  .chk_valid (chk_valid),
  .chk_match (chk_match),
  .busy      (busy),
  .spec_any  (spec_any),
  .valid_vec (valid_vec),
  .spec_vec  (spec_vec)
);

// File: tb/spec_line_tracker_bench.sv
module spec_line_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NL         = 64;
  localparam int IW         = 6;

  logic          clk;
  logic          rst_n;
  logic          wr_valid;
  logic [IW-1:0] wr_idx;
  logic          evict_req;
  logic [IW-1:0] evict_idx;
  logic          evict_ack, evict_wb, evict_stall, cmp_req, busy, spec_any;
  logic          chk_valid, chk_match;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural reference state
  bit m_vld [NL];
  bit m_drt [NL];
  bit m_spc [NL];
  bit m_busy;

  // last sampled outputs
  logic s_ack, s_wb, s_stall, s_cmp, s_busy, s_any;

  spec_line_tracker #(.NLINES(NL), .IDX_W(IW)) u_spec_line_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_idx      (wr_idx),
    .evict_req   (evict_req),
    .evict_idx   (evict_idx),
    .evict_ack   (evict_ack),
    .evict_wb    (evict_wb),
    .evict_stall (evict_stall),
    .cmp_req     (cmp_req),
    .chk_valid   (chk_valid),
    .chk_match   (chk_match),
    .busy        (busy),
    .spec_any    (spec_any)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic step(input bit wv, input int wi, input bit er, input int ei,
                      input bit cv, input bit cm);
    bit e_ack, e_wb, e_cmp, e_any;
    wr_valid  = wv;  wr_idx    = IW'(wi);
    evict_req = er;  evict_idx = IW'(ei);
    chk_valid = cv;  chk_match = cm;
    #1;
    e_any = 1'b0;
    foreach (m_spc[k]) if (m_spc[k]) e_any = 1'b1;
    e_ack = er && !m_busy && !m_spc[ei];
    e_wb  = e_ack && m_vld[ei] && m_drt[ei];
    e_cmp = er && !m_busy && m_spc[ei] && !cv;
    s_ack = evict_ack; s_wb = evict_wb; s_stall = evict_stall;
    s_cmp = cmp_req;   s_busy = busy;   s_any = spec_any;
    check("R7 evict_ack",   s_ack,   e_ack);
    check("R2 evict_wb",    s_wb,    e_wb);
    check("R4 evict_stall", s_stall, er && !e_ack);
    check("R3 cmp_req",     s_cmp,   e_cmp);
    check("R4 busy",        s_busy,  m_busy);
    check("R10 spec_any",   s_any,   e_any);
    @(posedge clk);
    if (e_ack) begin m_vld[ei] = 0; m_drt[ei] = 0; m_spc[ei] = 0; end
    if (cv) begin
      for (int k = 0; k < NL; k++) begin
        if (m_spc[k]) begin
          m_spc[k] = 0;
          if (!cm) begin m_vld[k] = 0; m_drt[k] = 0; end
        end
      end
    end
    if (wv) begin m_vld[wi] = 1; m_drt[wi] = 1; m_spc[wi] = 1; end
    if (cv) m_busy = 0;
    else if (e_cmp) m_busy = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit pr_er;
    int pr_ei;
    rst_n = 1'b0;
    wr_valid = 0; wr_idx = '0; evict_req = 0; evict_idx = '0;
    chk_valid = 0; chk_match = 0;
    foreach (m_vld[k]) begin m_vld[k] = 0; m_drt[k] = 0; m_spc[k] = 0; end
    m_busy = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset busy", busy, 1'b0);
    check("R11 reset spec_any", spec_any, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: untouched line evicts with no writeback; R1: write line 3
    step(0, 0, 1, 9, 0, 0);
    check("R11 clean line no wb", s_wb, 1'b0);
    step(1, 3, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R1 spec_any after write", s_any, 1'b1);

    // R3/R4/R5: evict speculative line 3, hold, match
    step(0, 0, 1, 3, 0, 0);
    check("R3 cmp on spec victim", s_cmp, 1'b1);
    step(0, 0, 1, 3, 0, 0);
    check("R4 stall while busy", s_stall, 1'b1);
    step(0, 0, 1, 3, 1, 1);
    check("R4 still busy in result cycle", s_busy, 1'b1);
    step(0, 0, 1, 3, 0, 0);
    check("R5 ack with wb after match", s_wb, 1'b1);
    step(0, 0, 1, 3, 0, 0);
    check("R8 re-evict no wb", s_wb, 1'b0);

    // R6: mismatch drops speculative lines 10 and 11
    step(1, 10, 0, 0, 0, 0);
    step(1, 11, 0, 0, 0, 0);
    step(0, 0, 1, 10, 0, 0);
    step(0, 0, 1, 10, 0, 1);
    step(0, 0, 1, 10, 1, 0);
    step(0, 0, 1, 10, 0, 0);
    check("R6 ack without wb after mismatch", s_wb, 1'b0);
    step(0, 0, 1, 11, 0, 0);
    check("R6 other spec line invalidated", s_wb, 1'b0);

    // R7: unsolicited match leaves line 20 dirty non-speculative
    step(1, 20, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 1, 20, 0, 0);
    check("R7 immediate ack", s_ack, 1'b1);
    check("R7 dirty wb", s_wb, 1'b1);

    // R9: write coinciding with mismatch stays speculative
    step(1, 31, 0, 0, 0, 0);
    step(1, 30, 0, 0, 1, 0);
    step(0, 0, 1, 30, 0, 0);
    check("R9 written line still spec", s_cmp, 1'b1);
    step(0, 0, 1, 30, 1, 0);
    step(0, 0, 1, 31, 0, 0);
    check("R9 older line killed", s_wb, 1'b0);

    // random traffic, stalled requests held
    pr_er = 0; pr_ei = 0;
    for (int c = 0; c < 4000; c++) begin
      bit wv, er, cv, cm;
      int wi, ei;
      wv = ($urandom_range(0, 3) == 0);
      wi = $urandom_range(0, NL-1);
      if (pr_er && s_stall) begin er = 1; ei = pr_ei; end
      else begin er = ($urandom_range(0, 2) == 0); ei = $urandom_range(0, NL-1); end
      cv = ($urandom_range(0, 9) == 0);
      cm = ($urandom_range(0, 1) == 0);
      step(wv, wi, er, ei, cv, cm);
      pr_er = er; pr_ei = ei;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule